// File: doc/BRIEF.md
# Programmable Bit-Rate Clock Generator

This block derives a synchronous transmit bit clock from the system reference clock. A 4-bit rate select word picks both the bit rate and the number of channels that share the bandwidth. The top bit of the word picks the timing mode. In normal mode the divider runs on every reference cycle. In halved mode an internal prescaler slows the divider to every second cycle. The block drives a square bit clock and a one-cycle strobe that marks each rising bit-clock edge, which is the point where transmit data is taken.

A pin chooses whether the bit clock is driven by the block or supplied from outside. A slave-mode pin forces the block to drive the clock whatever that pin says. When the clock comes from outside, the block stops driving it and produces the strobe from the rising edges of the external clock after synchronising them. A new select word takes effect only at a bit boundary, so no bit is ever shortened. The two select words that have no meaning in halved mode are refused: the block keeps its current setting and raises a flag. No data stream passes through the block, so it has no valid/ready interface and every pin is a plain level.

Top module: `bitclk_gen`

## Requirements
- R1: With rate_sel[3]=1 (normal mode), rate_sel[2:0] selects the bit period in reference cycles and the lane_code (0=one, 1=two, 2=four channels) as follows: 000→72/one, 001→144/one, 010→288/one, 011→576/one, 100→144/two, 101→288/two, 110→288/four, 111→576/four. In this mode dbl_active=0.
- R2: With rate_sel[3]=0 (halved mode), the legal codes are 001→144/one, 010→288/one, 011→576/one, 101→288/two, 000→576/two and 111→576/four, and dbl_active=1 while such a setting is in force.
- R3: While the block drives the clock, txcl_out has a period equal to the selected bit period. It is high for exactly the first half of each period, starting at the bit boundary.
- R4: While the block drives the clock, bit_strobe is high for exactly one cycle per bit, in the cycle where txcl_out goes high.
- R5: rate_sel is sampled only in the last cycle of a bit. A legal word loaded there sets lane_code, dbl_active and the new bit period from the next cycle on, and the new bit starts at its first cycle. A word that is present only between boundaries has no effect.
- R6: rate_sel values 0100 and 0110 are illegal. When one of them is present at a boundary, the setting in force is kept. code_invalid is 1 in the cycle after any cycle in which rate_sel holds an illegal value, and 0 otherwise.
- R7: txcl_oe is 1 when ext_clk_sel=0 or slave_mode=1. Otherwise txcl_oe is 0 and txcl_out is held low.
- R8: When txcl_oe=0, txcl_in passes through a two-stage synchroniser. bit_strobe is high for one cycle, two cycles after the edge that first samples txcl_in high following a low sample.
- R9: After reset the setting is normal mode, period 72, one channel, code_invalid=0, and the first bit begins in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 4 | Mode bit [3] and rate/channel code [2:0] |
| ext_clk_sel | input | 1 | 1 requests an externally supplied bit clock |
| slave_mode | input | 1 | 1 forces the block to drive the bit clock |
| txcl_in | input | 1 | External bit clock |
| txcl_out | output | 1 | Generated bit clock, low when not driven |
| txcl_oe | output | 1 | Output enable for the bit-clock pad |
| bit_strobe | output | 1 | One-cycle marker of each rising bit-clock edge |
| lane_code | output | 2 | Channel count of the setting in force |
| dbl_active | output | 1 | Halved timing mode in force |
| code_invalid | output | 1 | Previous cycle held an illegal select word |

## Verification
Two events can fall in the same cycle: a bit boundary, where a new setting loads and the counter restarts, and a change of rate_sel. The bench changes rate_sel in every phase of a bit, including the boundary cycle itself and short bursts of words that appear and disappear inside one bit. It also puts an illegal word on the input at a boundary. A behavioural model counts the cycles within each bit and tracks the setting in force. Every output is compared with that model in every cycle.

// File: rtl/bitclk_pkg.sv
package bitclk_pkg;

  typedef enum logic [1:0] {
    LANES_ONE  = 2'd0,
    LANES_TWO  = 2'd1,
    LANES_FOUR = 2'd2
  } lanes_e;

  // rate_idx: 0..3 = base period x1, x2, x4, x8
  typedef struct packed {
    logic [1:0] rate_idx;
    lanes_e     lanes;
    logic       dbl;
  } rate_cfg_t;

  localparam rate_cfg_t CFG_RESET = '{rate_idx: 2'd0, lanes: LANES_ONE, dbl: 1'b0};

  function automatic logic sel_is_legal(input logic [3:0] sel);
    return !(!sel[3] && (sel[2:0] == 3'b100 || sel[2:0] == 3'b110));
  endfunction

endpackage

// File: rtl/bitclk_decode.sv
module bitclk_decode
  import bitclk_pkg::*;
(
  input  logic [3:0] sel,
  output rate_cfg_t  cfg,
  output logic       legal
);

  always_comb begin
    cfg   = CFG_RESET;
    legal = sel_is_legal(sel);
    cfg.dbl = ~sel[3];
    if (sel[3]) begin
      unique case (sel[2:0])
        3'b000: begin cfg.rate_idx = 2'd0; cfg.lanes = LANES_ONE;  end
        3'b001: begin cfg.rate_idx = 2'd1; cfg.lanes = LANES_ONE;  end
        3'b010: begin cfg.rate_idx = 2'd2; cfg.lanes = LANES_ONE;  end
        3'b011: begin cfg.rate_idx = 2'd3; cfg.lanes = LANES_ONE;  end
        3'b100: begin cfg.rate_idx = 2'd1; cfg.lanes = LANES_TWO;  end
        3'b101: begin cfg.rate_idx = 2'd2; cfg.lanes = LANES_TWO;  end
        3'b110: begin cfg.rate_idx = 2'd2; cfg.lanes = LANES_FOUR; end
        default: begin cfg.rate_idx = 2'd3; cfg.lanes = LANES_FOUR; end
      endcase
    end else begin
      unique case (sel[2:0])
        3'b001: begin cfg.rate_idx = 2'd1; cfg.lanes = LANES_ONE;  end
        3'b010: begin cfg.rate_idx = 2'd2; cfg.lanes = LANES_ONE;  end
        3'b011: begin cfg.rate_idx = 2'd3; cfg.lanes = LANES_ONE;  end
        3'b101: begin cfg.rate_idx = 2'd2; cfg.lanes = LANES_TWO;  end
        3'b000: begin cfg.rate_idx = 2'd3; cfg.lanes = LANES_TWO;  end
        3'b111: begin cfg.rate_idx = 2'd3; cfg.lanes = LANES_FOUR; end
        default: begin cfg.rate_idx = 2'd1; cfg.lanes = LANES_ONE; end
      endcase
    end
  end

endmodule

// File: rtl/bitclk_divider.sv
module bitclk_divider
  import bitclk_pkg::*;
#(
  parameter int BASE_DIV = 72
) (
  input  logic      clk,
  input  logic      rst_n,
  input  rate_cfg_t cfg_next,
  input  logic      cfg_legal,
  output rate_cfg_t cfg_q,
  output logic      gen_clk,
  output logic      gen_strobe
);

  localparam int MAX_DIV = BASE_DIV * 8;
  localparam int CNT_W   = $clog2(MAX_DIV + 1);

  logic [CNT_W-1:0] cnt;
  logic             ph;
  logic [CNT_W-1:0] lim;
  logic [1:0]       shamt;
  logic             tick;
  logic             last;

  // In halved mode the counter advances every second cycle, so it needs half the ticks
  always_comb begin
    shamt = cfg_q.rate_idx - {1'b0, cfg_q.dbl};
    lim   = CNT_W'(BASE_DIV) << shamt;
  end

  assign tick = !cfg_q.dbl || ph;
  assign last = tick && (cnt == lim - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ph    <= 1'b0;
      cfg_q <= CFG_RESET;
    end else if (last) begin
      cnt <= '0;
      ph  <= 1'b0;
      if (cfg_legal) cfg_q <= cfg_next;
    end else begin
      if (cfg_q.dbl) ph <= ~ph;
      if (tick) cnt <= cnt + CNT_W'(1);
    end
  end

  assign gen_clk    = cnt < (lim >> 1);
  assign gen_strobe = (cnt == '0) && !ph;

endmodule

// File: rtl/bitclk_pad.sv
module bitclk_pad #(
  parameter int SYNC_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk_sel,
  input  logic slave_mode,
  input  logic gen_clk,
  input  logic gen_strobe,
  input  logic ext_clk,
  output logic pad_out,
  output logic pad_oe,
  output logic strobe
);

  logic [SYNC_LEN-1:0] sync_q;
  logic                prev_q;
  logic                ext_rise;

  genvar g;
  generate
    for (g = 0; g < SYNC_LEN; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= ext_clk;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_LEN-1];

  assign ext_rise = sync_q[SYNC_LEN-1] && !prev_q;
  assign pad_oe   = slave_mode || !ext_clk_sel;
  assign pad_out  = pad_oe && gen_clk;
  assign strobe   = pad_oe ? gen_strobe : ext_rise;

endmodule

// File: rtl/bitclk_gen.sv
module bitclk_gen
  import bitclk_pkg::*;
#(
  parameter int BASE_DIV = 72,
  parameter int SYNC_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] rate_sel,
  input  logic       ext_clk_sel,
  input  logic       slave_mode,
  input  logic       txcl_in,
  output logic       txcl_out,
  output logic       txcl_oe,
  output logic       bit_strobe,
  output logic [1:0] lane_code,
  output logic       dbl_active,
  output logic       code_invalid
);

  rate_cfg_t cfg_dec;
  rate_cfg_t cfg_cur;
  logic      dec_legal;
  logic      gen_clk;
  logic      gen_strobe;

  bitclk_decode u_dec (
    .sel   (rate_sel),
    .cfg   (cfg_dec),
    .legal (dec_legal)
  );

  bitclk_divider #(.BASE_DIV(BASE_DIV)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_next   (cfg_dec),
    .cfg_legal  (dec_legal),
    .cfg_q      (cfg_cur),
    .gen_clk    (gen_clk),
    .gen_strobe (gen_strobe)
  );

  bitclk_pad #(.SYNC_LEN(SYNC_LEN)) u_pad (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_clk_sel (ext_clk_sel),
    .slave_mode  (slave_mode),
    .gen_clk     (gen_clk),
    .gen_strobe  (gen_strobe),
    .ext_clk     (txcl_in),
    .pad_out     (txcl_out),
    .pad_oe      (txcl_oe),
    .strobe      (bit_strobe)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) code_invalid <= 1'b0;
    else        code_invalid <= !dec_legal;

  assign lane_code  = cfg_cur.lanes;
  assign dbl_active = cfg_cur.dbl;

endmodule

// File: rtl/bitclk_gen_chk.sv
module bitclk_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] rate_sel,
  input logic       ext_clk_sel,
  input logic       slave_mode,
  input logic       txcl_out,
  input logic       txcl_oe,
  input logic       bit_strobe,
  input logic [1:0] lane_code,
  input logic       dbl_active,
  input logic       code_invalid
);

  logic sel_bad;
  assign sel_bad = !rate_sel[3] && (rate_sel[2:0] == 3'b100 || rate_sel[2:0] == 3'b110);

  assert_strobe_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (txcl_oe && $past(txcl_oe) && $rose(txcl_out)) |-> bit_strobe);

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (txcl_oe && bit_strobe) |=> (!bit_strobe || !txcl_oe));

  assert_pad_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_clk_sel && !slave_mode) |-> (!txcl_oe && !txcl_out));

  assert_change_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (txcl_oe && (lane_code != $past(lane_code) || dbl_active != $past(dbl_active)))
      |-> bit_strobe);

  assert_flag_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_bad |=> code_invalid);

  assert_hold_on_bad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_code != $past(lane_code)) |-> !(!$past(rate_sel[3]) &&
      ($past(rate_sel[2:0]) == 3'b100 || $past(rate_sel[2:0]) == 3'b110)));

  assert_lane_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lane_code != 2'b11);

endmodule

bind bitclk_gen bitclk_gen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rate_sel     (rate_sel),
  .ext_clk_sel  (ext_clk_sel),
  .slave_mode   (slave_mode),
  .txcl_out     (txcl_out),
  .txcl_oe      (txcl_oe),
  .bit_strobe   (bit_strobe),
  .lane_code    (lane_code),
  .dbl_active   (dbl_active),
  .code_invalid (code_invalid)
);

// File: tb/bitclk_gen_bench.sv
module bitclk_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] rate_sel = 4'b1000;
  logic       ext_clk_sel = 1'b0;
  logic       slave_mode = 1'b0;
  logic       txcl_in = 1'b0;
  logic       txcl_out, txcl_oe, bit_strobe, dbl_active, code_invalid;
  logic [1:0] lane_code;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  bitclk_gen u_bitclk_gen (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .ext_clk_sel(ext_clk_sel),
    .slave_mode(slave_mode), .txcl_in(txcl_in), .txcl_out(txcl_out),
    .txcl_oe(txcl_oe), .bit_strobe(bit_strobe), .lane_code(lane_code),
    .dbl_active(dbl_active), .code_invalid(code_invalid)
  );

  // ---- behavioural reference ----
  int m_period, m_lanes, m_pos;
  bit m_dbl, m_inv;
  bit m_s1, m_s2, m_s3;

  task automatic spec_lookup(input logic [3:0] s, output int per, output int ln,
                             output bit dbl, output bit ok);
    ok = 1; dbl = !s[3]; per = 0; ln = 0;
    case (s)
      4'b1000: begin per = 72;  ln = 0; end
      4'b1001: begin per = 144; ln = 0; end
      4'b1010: begin per = 288; ln = 0; end
      4'b1011: begin per = 576; ln = 0; end
      4'b1100: begin per = 144; ln = 1; end
      4'b1101: begin per = 288; ln = 1; end
      4'b1110: begin per = 288; ln = 2; end
      4'b1111: begin per = 576; ln = 2; end
      4'b0001: begin per = 144; ln = 0; end
      4'b0010: begin per = 288; ln = 0; end
      4'b0011: begin per = 576; ln = 0; end
      4'b0101: begin per = 288; ln = 1; end
      4'b0000: begin per = 576; ln = 1; end
      4'b0111: begin per = 576; ln = 2; end
      default: ok = 0;
    endcase
  endtask

  task automatic miss(input string req, input string what, input int act, input int exp);
    misses++;
    $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
  endtask

  always @(posedge clk) begin
    int per, ln; bit dbl, ok;
    cycles++;
    if (!rst_n) begin
      m_period = 72; m_lanes = 0; m_dbl = 0; m_pos = 0; m_inv = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      spec_lookup(rate_sel, per, ln, dbl, ok);
      m_inv = !ok;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = txcl_in;
      if (m_pos == m_period - 1) begin
        m_pos = 0;
        if (ok) begin m_period = per; m_lanes = ln; m_dbl = dbl; end
      end else m_pos++;
      #2;
      begin
        bit oe, exp_out, exp_stb;
        oe      = slave_mode || !ext_clk_sel;
        exp_out = oe && (m_pos < m_period / 2);
        exp_stb = oe ? (m_pos == 0) : (m_s2 && !m_s3);
        vectors++;
        if (txcl_oe !== oe)            miss("R7", "txcl_oe", txcl_oe, oe);
        if (txcl_out !== exp_out)      miss(oe ? "R3" : "R7", "txcl_out", txcl_out, exp_out);
        if (bit_strobe !== exp_stb)    miss(oe ? "R4" : "R8", "bit_strobe", bit_strobe, exp_stb);
        if (lane_code !== 2'(m_lanes)) miss("R1/R2/R5", "lane_code", lane_code, m_lanes);
        if (dbl_active !== m_dbl)      miss("R2/R5", "dbl_active", dbl_active, m_dbl);
        if (code_invalid !== m_inv)    miss("R6", "code_invalid", code_invalid, m_inv);
      end
    end
  end

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  always @(posedge clk) if (cycles > 150000 && !done) begin
    done = 1;
    misses++;
    $display("FAIL watchdog: actual %0d expected < 150000 cycles", cycles);
    finish_run();
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run(3);
    // R9 reset state while held in reset
    vectors++;
    if (lane_code !== 2'd0 || dbl_active !== 1'b0 || code_invalid !== 1'b0 || txcl_oe !== 1'b1)
      miss("R9", "reset lane/dbl/inv/oe", {lane_code, dbl_active, code_invalid, txcl_oe}, 5'b00001);
    rst_n = 1'b1;
    run(200);
    // R1/R2/R6: every select word, dwell long enough for two boundaries
    for (int i = 0; i < 16; i++) begin
      rate_sel = 4'(i);
      run(1300);
    end
    // R5: words that live only inside a bit, and changes near boundaries
    rate_sel = 4'b1011; run(1200);
    rate_sel = 4'b1000; run(50);
    rate_sel = 4'b1111; run(50);
    rate_sel = 4'b1001; run(700);
    for (int k = 0; k < 12; k++) begin
      rate_sel = (k % 2 == 0) ? 4'b1000 : 4'b0001;
      run(71 + k);
    end
    // R6: illegal word sitting across a boundary holds the setting
    rate_sel = 4'b0101; run(700);
    rate_sel = 4'b0110; run(700);
    rate_sel = 4'b1000; run(300);
    // R8: external clock
    ext_clk_sel = 1'b1;
    for (int k = 0; k < 20; k++) begin
      txcl_in = ~txcl_in;
      run(7 + (k % 3));
    end
    // R7: slave mode overrides the external request
    slave_mode = 1'b1; run(400);
    slave_mode = 1'b0; run(50);
    ext_clk_sel = 1'b0; run(400);
    done = 1;
    finish_run();
  end

endmodule